// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block schedules conversions on an external analog-to-digital converter. Two sequencers each walk an ordered list of up to four conversion slots, and each slot names one of sixteen input channels. They share one converter through a request/ready handshake. The block keeps the most recent 16-bit result in a readable register. When cascading is enabled the two slot lists join into a single sequence of up to eight slots, driven by the first sequencer.

A sequence can be started by a software command, by a single-cycle timer trigger, or by the rising edge of an external start pin. The pin is synchronised inside the block, and the timer and the pin each have their own enable bit. A sequence either stops after its last slot (start/stop mode) or restarts at once from slot 0 (continuous mode). A start that arrives while a sequence is running is held as a single pending start. Each sequencer has an interrupt flag that can be set after every conversion or only at the end of the sequence. Software clears the flag by writing 1 to it. A reset command returns the sequencer to slot 0 and leaves the configuration as it was.

Software reaches the block through a small word-wide register port: a write strobe, a 3-bit address, write data, and combinational read data.

Top module: `adcseq_ctrl`

## Requirements
- R1: After reset every register reads 0, `adc_req` is low and both interrupt lines are low.
- R2: Address 0 holds the slot channels of sequencer A and address 1 those of sequencer B. Slot k takes its channel from bits [4k+3:4k], so slot 0 is bits 3:0. The channel of the slot being converted is presented on `adc_ch`.
- R3: The configuration register (address 2) holds these fields: bit 0 cascade, bit 1 continuous, bits 3:2 A slot count minus 1, bits 5:4 B slot count minus 1, bits 7:6 A interrupt mode, bits 9:8 B interrupt mode, bit 10 timer enable for A, bit 11 pin enable for A, bit 12 timer enable for B. Slots are converted in ascending order starting at slot 0.
- R4: In start/stop mode a sequencer converts its last slot and then goes idle: busy clears and no further request is made.
- R5: In continuous mode the sequencer goes from its last slot straight back to slot 0 and stays busy. Clearing the continuous bit stops it at the end of the sequence in progress.
- R6: A sequence starts on a software start command, on a high `tmr_trig` when the matching timer enable is set, or on a rising edge of `ext_soc` when the pin enable is set. A disabled source has no effect.
- R7: A start received while the sequencer is busy is held as one pending start and runs after the current sequence. Further starts received while a start is already pending are dropped.
- R8: Interrupt mode 01 sets the flag after every conversion. Mode 10 sets it only after the last slot. Modes 00 and 11 never set it. `irq_a` and `irq_b` follow the flags.
- R9: The control/status register is address 3. Writing 1 to bit 1 (A) or bit 5 (B) clears that flag, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins. When read, bits 0, 1 and 2 give A's busy, flag and pending state, and bits 4, 5 and 6 give the same for B.
- R10: Writing 1 to bit 3 (A) or bit 7 (B) of address 3 clears that sequencer's busy and pending state and returns it to slot 0. The bit does not stay set, and no configuration register changes. Writing 1 to bit 0 (A) or bit 4 (B) is the software start.
- R11: In cascaded mode, sequencer A converts its own slots 0..countA-1 and then B's slots 0..countB-1. Every start for sequencer B is ignored.
- R12: One converter is shared. `adc_req` and `adc_ch` are held until `adc_ready` is seen. If both sequencers want a conversion, A is served first. Address 4 returns the data of the last completed conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| tmr_trig | input | 1 | Timer start trigger, single-cycle pulse |
| ext_soc | input | 1 | External start pin (asynchronous) |
| adc_req | output | 1 | Conversion request to the converter |
| adc_ch | output | 4 | Channel for the requested conversion |
| adc_ready | input | 1 | Converter result valid, one cycle |
| adc_data | input | 16 | Converter result |
| irq_a | output | 1 | Interrupt of sequencer A |
| irq_b | output | 1 | Interrupt of sequencer B |

## Verification
Two functions can land in the same cycle: the write-1-to-clear of a flag, and the flag being set by a completing conversion. The converter model in the bench drives the clear write on exactly the edge where it returns `adc_ready`, with the interrupt mode set to every conversion. The bench then expects `irq_a` to stay high. A second collision is a software reset of a sequencer while one of its conversions is in flight. The bench judges it from busy, request and configuration readback, and from a restart that must begin at slot 0.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [0:0] {ENG_IDLE = 1'b0, ENG_WAIT = 1'b1} eng_state_e;
  typedef enum logic [1:0] {IRQ_NONE = 2'b00, IRQ_EACH = 2'b01,
                            IRQ_LAST = 2'b10, IRQ_RSVD = 2'b11} irq_mode_e;
  localparam int unsigned ADDR_W    = 3;
  localparam logic [2:0]  RA_CHAN_A = 3'd0;
  localparam logic [2:0]  RA_CHAN_B = 3'd1;
  localparam logic [2:0]  RA_CFG    = 3'd2;
  localparam logic [2:0]  RA_CTL    = 3'd3;
  localparam logic [2:0]  RA_RES    = 3'd4;
  // control/status bit positions
  localparam int unsigned CB_GO_A   = 0;
  localparam int unsigned CB_FLG_A  = 1;
  localparam int unsigned CB_PND_A  = 2;
  localparam int unsigned CB_HOME_A = 3;
  localparam int unsigned CB_GO_B   = 4;
  localparam int unsigned CB_FLG_B  = 5;
  localparam int unsigned CB_PND_B  = 6;
  localparam int unsigned CB_HOME_B = 7;
endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CH_W   = 4,
  parameter int unsigned SLOTS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output logic [CH_W*SLOTS-1:0]   chan_a,
  output logic [CH_W*SLOTS-1:0]   chan_b,
  output logic                    casc,
  output logic                    cont,
  output logic [$clog2(SLOTS)-1:0] cnt_a,
  output logic [$clog2(SLOTS)-1:0] cnt_b,
  output logic [1:0]              mode_a,
  output logic [1:0]              mode_b,
  output logic                    tmr_en_a,
  output logic                    pin_en_a,
  output logic                    tmr_en_b,
  output logic                    go_a,
  output logic                    clr_a,
  output logic                    home_a,
  output logic                    go_b,
  output logic                    clr_b,
  output logic                    home_b,
  input  logic                    busy_a,
  input  logic                    flag_a,
  input  logic                    pend_a,
  input  logic                    busy_b,
  input  logic                    flag_b,
  input  logic                    pend_b,
  input  logic [DATA_W-1:0]       result
);
  localparam int unsigned LEN_W  = $clog2(SLOTS);
  localparam int unsigned CHAN_W = CH_W * SLOTS;
  localparam int unsigned F_CNTA = 2;
  localparam int unsigned F_CNTB = F_CNTA + LEN_W;
  localparam int unsigned F_MODA = F_CNTB + LEN_W;
  localparam int unsigned F_MODB = F_MODA + 2;
  localparam int unsigned F_TMRA = F_MODB + 2;
  localparam int unsigned F_PINA = F_TMRA + 1;
  localparam int unsigned F_TMRB = F_PINA + 1;
  localparam int unsigned CFG_W  = F_TMRB + 1;

  logic [CHAN_W-1:0] chan_a_q, chan_a_d;
  logic [CHAN_W-1:0] chan_b_q, chan_b_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              ctl_wr;

  always_comb begin
    chan_a_d = chan_a_q;
    chan_b_d = chan_b_q;
    cfg_d    = cfg_q;
    if (wr) begin
      case (addr)
        RA_CHAN_A: chan_a_d = wdata[CHAN_W-1:0];
        RA_CHAN_B: chan_b_d = wdata[CHAN_W-1:0];
        RA_CFG:    cfg_d    = wdata[CFG_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_a_q <= '0;
      chan_b_q <= '0;
      cfg_q    <= '0;
    end else begin
      chan_a_q <= chan_a_d;
      chan_b_q <= chan_b_d;
      cfg_q    <= cfg_d;
    end
  end

  assign ctl_wr   = wr && (addr == RA_CTL);
  assign go_a     = ctl_wr && wdata[CB_GO_A];
  assign clr_a    = ctl_wr && wdata[CB_FLG_A];
  assign home_a   = ctl_wr && wdata[CB_HOME_A];
  assign go_b     = ctl_wr && wdata[CB_GO_B];
  assign clr_b    = ctl_wr && wdata[CB_FLG_B];
  assign home_b   = ctl_wr && wdata[CB_HOME_B];

  assign chan_a   = chan_a_q;
  assign chan_b   = chan_b_q;
  assign casc     = cfg_q[0];
  assign cont     = cfg_q[1];
  assign cnt_a    = cfg_q[F_CNTA +: LEN_W];
  assign cnt_b    = cfg_q[F_CNTB +: LEN_W];
  assign mode_a   = cfg_q[F_MODA +: 2];
  assign mode_b   = cfg_q[F_MODB +: 2];
  assign tmr_en_a = cfg_q[F_TMRA];
  assign pin_en_a = cfg_q[F_PINA];
  assign tmr_en_b = cfg_q[F_TMRB];

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CHAN_A: rdata[CHAN_W-1:0] = chan_a_q;
      RA_CHAN_B: rdata[CHAN_W-1:0] = chan_b_q;
      RA_CFG:    rdata[CFG_W-1:0]  = cfg_q;
      RA_CTL: begin
        rdata[CB_GO_A]  = busy_a;
        rdata[CB_FLG_A] = flag_a;
        rdata[CB_PND_A] = pend_a;
        rdata[CB_GO_B]  = busy_b;
        rdata[CB_FLG_B] = flag_b;
        rdata[CB_PND_B] = pend_b;
      end
      RA_RES:    rdata = result;
      default:   rdata = '0;
    endcase
  end

  AST_CFG_KEPT_ON_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ($stable(cfg_q) && $stable(chan_a_q) && $stable(chan_b_q))); // R10
endmodule

// File: rtl/adcseq_seq.sv
module adcseq_seq
  import adcseq_pkg::*;
#(
  parameter int unsigned CH_W     = 4,
  parameter int unsigned SLOTS    = 4,
  parameter bit          CASC_CAP = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CH_W*SLOTS-1:0]    chan_own,
  input  logic [CH_W*SLOTS-1:0]    chan_ext,
  input  logic [$clog2(SLOTS)-1:0] cnt_own,
  input  logic [$clog2(SLOTS)-1:0] cnt_ext,
  input  logic                     casc,
  input  logic                     cont,
  input  logic [1:0]               mode,
  input  logic                     start,
  input  logic                     home,
  input  logic                     clr,
  input  logic                     done,
  output logic                     busy,
  output logic                     pend,
  output logic                     flag,
  output logic                     conv_req,
  output logic [CH_W-1:0]          conv_ch
);
  localparam int unsigned LEN_W = $clog2(SLOTS);
  localparam int unsigned PTR_W = LEN_W + 1;

  logic             busy_q, busy_d;
  logic             pend_q, pend_d;
  logic             flag_q, flag_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] last_idx;
  logic [PTR_W-1:0] ext_ptr;
  logic             in_own;
  logic             at_last;
  logic             step;
  logic             flag_set;
  logic             casc_eff;

  generate
    if (CASC_CAP) begin : g_casc
      assign casc_eff = casc;
    end else begin : g_solo
      assign casc_eff = 1'b0;
    end
  endgenerate

  assign last_idx = casc_eff ? ({1'b0, cnt_own} + {1'b0, cnt_ext} + PTR_W'(1))
                             : {1'b0, cnt_own};
  assign in_own   = (ptr_q <= {1'b0, cnt_own});
  assign ext_ptr  = ptr_q - {1'b0, cnt_own} - PTR_W'(1);
  assign conv_ch  = in_own ? chan_own[ptr_q[LEN_W-1:0]*CH_W +: CH_W]
                           : chan_ext[ext_ptr[LEN_W-1:0]*CH_W +: CH_W];
  assign at_last  = (ptr_q >= last_idx);
  assign step     = done && busy_q;

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    ptr_d  = ptr_q;
    if (home) begin
      busy_d = 1'b0;
      pend_d = 1'b0;
      ptr_d  = '0;
    end else if (step && at_last) begin
      ptr_d = '0;
      if (cont) begin
        busy_d = 1'b1;
        pend_d = 1'b0;
      end else if (pend_q) begin
        busy_d = 1'b1;
        pend_d = start;
      end else begin
        busy_d = start;
        pend_d = 1'b0;
      end
    end else if (step) begin
      ptr_d = ptr_q + PTR_W'(1);
      if (start) pend_d = 1'b1;
    end else if (start) begin
      if (busy_q) pend_d = 1'b1;
      else        busy_d = 1'b1;
    end
  end

  always_comb begin
    case (irq_mode_e'(mode))
      IRQ_EACH: flag_set = step;
      IRQ_LAST: flag_set = step && at_last;
      default:  flag_set = 1'b0;
    endcase
    flag_d = flag_set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      ptr_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      ptr_q  <= ptr_d;
      flag_q <= flag_d;
    end
  end

  assign busy     = busy_q;
  assign pend     = pend_q;
  assign flag     = flag_q;
  assign conv_req = busy_q;

  AST_HOME_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    home |=> (!busy_q && !pend_q && (ptr_q == '0))); // R10
  AST_PEND_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> busy_q); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (irq_mode_e'(mode) == IRQ_EACH)) |=> flag_q); // R9
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !step) |=> !flag_q); // R9
  AST_CONT_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cont && !home) |=> busy_q); // R5
endmodule

// File: rtl/adcseq_eng.sv
module adcseq_eng
  import adcseq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_a,
  input  logic [CH_W-1:0]   ch_a,
  input  logic              req_b,
  input  logic [CH_W-1:0]   ch_b,
  output logic              adc_req,
  output logic [CH_W-1:0]   adc_ch,
  input  logic              adc_ready,
  input  logic [DATA_W-1:0] adc_data,
  output logic              done_a,
  output logic              done_b,
  output logic [DATA_W-1:0] result
);
  eng_state_e        st_q, st_d;
  logic              own_q, own_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [DATA_W-1:0] res_q;
  logic              res_en;

  always_comb begin
    st_d  = st_q;
    own_d = own_q;
    ch_d  = ch_q;
    case (st_q)
      ENG_IDLE: begin
        if (req_a) begin
          st_d  = ENG_WAIT;
          own_d = 1'b0;
          ch_d  = ch_a;
        end else if (req_b) begin
          st_d  = ENG_WAIT;
          own_d = 1'b1;
          ch_d  = ch_b;
        end
      end
      ENG_WAIT: if (adc_ready) st_d = ENG_IDLE;
      default:  st_d = ENG_IDLE;
    endcase
  end

  assign res_en = (st_q == ENG_WAIT) && adc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      own_q <= 1'b0;
      ch_q  <= '0;
      res_q <= '0;
    end else begin
      st_q  <= st_d;
      own_q <= own_d;
      ch_q  <= ch_d;
      if (res_en) res_q <= adc_data;
    end
  end

  assign adc_req = (st_q == ENG_WAIT);
  assign adc_ch  = ch_q;
  assign done_a  = res_en && !own_q;
  assign done_b  = res_en && own_q;
  assign result  = res_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_ready) |=> (adc_req && $stable(adc_ch))); // R12
  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_a && done_b)); // R12
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(adc_req && adc_ready) |=> $stable(result)); // R12
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CH_W     = 4,
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned PIN_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmr_trig,
  input  logic              ext_soc,
  output logic              adc_req,
  output logic [CH_W-1:0]   adc_ch,
  input  logic              adc_ready,
  input  logic [DATA_W-1:0] adc_data,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int unsigned LEN_W  = $clog2(SLOTS);
  localparam int unsigned CHAN_W = CH_W * SLOTS;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [CHAN_W-1:0] chan_a, chan_b;
  logic              casc, cont, tmr_en_a, pin_en_a, tmr_en_b;
  logic [LEN_W-1:0]  cnt_a, cnt_b;
  logic [1:0]        mode_a, mode_b;
  logic              go_a, clr_a, home_a, go_b, clr_b, home_b;
  logic              busy_a, pend_a, flag_a, busy_b, pend_b, flag_b;
  logic              req_a, req_b, done_a, done_b;
  logic [CH_W-1:0]   ch_a, ch_b;
  logic [DATA_W-1:0] result;
  logic              pin_rise;
  logic              start_a, start_b;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  adcseq_regs #(.DATA_W(DATA_W), .CH_W(CH_W), .SLOTS(SLOTS)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .chan_a(chan_a), .chan_b(chan_b), .casc(casc), .cont(cont),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .mode_a(mode_a), .mode_b(mode_b),
    .tmr_en_a(tmr_en_a), .pin_en_a(pin_en_a), .tmr_en_b(tmr_en_b),
    .go_a(go_a), .clr_a(clr_a), .home_a(home_a),
    .go_b(go_b), .clr_b(clr_b), .home_b(home_b),
    .busy_a(busy_a), .flag_a(flag_a), .pend_a(pend_a),
    .busy_b(busy_b), .flag_b(flag_b), .pend_b(pend_b),
    .result(result));

  adcseq_sync #(.STAGES(PIN_SYNC)) u_pin (
    .clk(clk), .rst_n(rst_int_n), .pin(ext_soc), .rise(pin_rise));

  assign start_a = go_a | (tmr_trig & tmr_en_a) | (pin_rise & pin_en_a);
  assign start_b = ~casc & (go_b | (tmr_trig & tmr_en_b));

  adcseq_seq #(.CH_W(CH_W), .SLOTS(SLOTS), .CASC_CAP(1'b1)) u_seq_a (
    .clk(clk), .rst_n(rst_int_n), .chan_own(chan_a), .chan_ext(chan_b),
    .cnt_own(cnt_a), .cnt_ext(cnt_b), .casc(casc), .cont(cont),
    .mode(mode_a), .start(start_a), .home(home_a), .clr(clr_a),
    .done(done_a), .busy(busy_a), .pend(pend_a), .flag(flag_a),
    .conv_req(req_a), .conv_ch(ch_a));

  adcseq_seq #(.CH_W(CH_W), .SLOTS(SLOTS), .CASC_CAP(1'b0)) u_seq_b (
    .clk(clk), .rst_n(rst_int_n), .chan_own(chan_b), .chan_ext('0),
    .cnt_own(cnt_b), .cnt_ext('0), .casc(1'b0), .cont(cont),
    .mode(mode_b), .start(start_b), .home(home_b), .clr(clr_b),
    .done(done_b), .busy(busy_b), .pend(pend_b), .flag(flag_b),
    .conv_req(req_b), .conv_ch(ch_b));

  adcseq_eng #(.DATA_W(DATA_W), .CH_W(CH_W)) u_eng (
    .clk(clk), .rst_n(rst_int_n), .req_a(req_a), .ch_a(ch_a),
    .req_b(req_b), .ch_b(ch_b), .adc_req(adc_req), .adc_ch(adc_ch),
    .adc_ready(adc_ready), .adc_data(adc_data),
    .done_a(done_a), .done_b(done_b), .result(result));

  assign irq_a = flag_a;
  assign irq_b = flag_b;

  AST_CASC_B_SILENT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (casc && !busy_b) |=> !busy_b); // R11
  AST_IDLE_NO_SERVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_a && !busy_b && !adc_req) |=> !adc_req); // R4
endmodule

// File: tb/tb_adcseq_ctrl.sv
module tb_adcseq_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] WA = 16'hB852;
  localparam logic [15:0] WB = 16'h4E17;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tmr_trig;
  logic        ext_soc;
  logic        adc_req;
  logic [3:0]  adc_ch;
  logic        adc_ready;
  logic [15:0] adc_data;
  logic        irq_a;
  logic        irq_b;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned conv_n = 0;
  bit          clr_hit = 1'b0;
  bit          finished = 1'b0;
  logic [3:0]  ch_log  [64];
  logic        irq_log [64];
  logic [15:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcseq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_trig(tmr_trig),
    .ext_soc(ext_soc), .adc_req(adc_req), .adc_ch(adc_ch),
    .adc_ready(adc_ready), .adc_data(adc_data), .irq_a(irq_a), .irq_b(irq_b));

  function automatic logic [3:0] nib(logic [15:0] w, int i);
    return w[i*4 +: 4];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rdreg(3'd3, s);
      if (!s[0] && !s[4] && !adc_req) break;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // converter model: answers a request after a short latency
  initial begin
    adc_ready = 1'b0; adc_data = '0;
    forever begin
      @(negedge clk);
      if (adc_req && !adc_ready) begin
        repeat (2) @(negedge clk);
        ch_log[conv_n % 64] = adc_ch;
        adc_data  = {4'h5, conv_n[7:0], adc_ch};
        adc_ready = 1'b1;
        if (clr_hit) begin
          bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 16'h0002;
        end
        @(negedge clk);
        adc_ready = 1'b0;
        irq_log[conv_n % 64] = irq_a;
        if (clr_hit) begin
          bus_wr = 1'b0; clr_hit = 1'b0;
        end
        conv_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    tmr_trig = 1'b0; ext_soc = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rdreg(3'(a), rd);
      chk(rd == 16'h0, "R1 reg", rd, 0);
    end
    chk(!adc_req && !irq_a && !irq_b, "R1 outputs", {adc_req, irq_a, irq_b}, 0);

    wr(3'd0, WA);
    wr(3'd1, WB);

    // R2 R3 R4 R8: sweep slot count and interrupt mode on sequencer A
    for (int m = 0; m < 4; m++) begin
      for (int len = 0; len < 4; len++) begin
        wr(3'd2, 16'((len << 2) | (m << 6)));
        wr(3'd3, 16'h0002);
        conv_n = 0;
        wr(3'd3, 16'h0001);
        wait_idle();
        idle(6);
        chk(conv_n == len + 1, "R3 count", conv_n, len + 1);
        chk(!adc_req, "R4 halted", adc_req, 0);
        for (int i = 0; i <= len; i++) begin
          chk(ch_log[i] == nib(WA, i), "R2 channel", ch_log[i], nib(WA, i));
          chk(irq_log[i] == ((m == 1) || (m == 2 && i == len)), "R8 irq",
              irq_log[i], (m == 1) || (m == 2 && i == len));
        end
      end
    end

    // R11 cascaded order sweep
    for (int la = 0; la < 4; la++) begin
      for (int lb = 0; lb < 4; lb++) begin
        wr(3'd2, 16'(1 | (la << 2) | (lb << 4)));
        conv_n = 0;
        wr(3'd3, 16'h0001);
        wait_idle();
        chk(conv_n == la + lb + 2, "R11 count", conv_n, la + lb + 2);
        for (int i = 0; i < la + lb + 2; i++) begin
          logic [3:0] e;
          e = (i <= la) ? nib(WA, i) : nib(WB, i - la - 1);
          chk(ch_log[i] == e, "R11 order", ch_log[i], e);
        end
      end
    end

    // R11 start of B ignored when cascaded
    conv_n = 0;
    wr(3'd3, 16'h0010);
    idle(12);
    rdreg(3'd3, rd);
    chk(conv_n == 0 && !rd[4], "R11 B start ignored", conv_n, 0);

    // R6 timer trigger gated by its enable
    wr(3'd2, 16'(1 << 2));
    conv_n = 0;
    @(negedge clk); tmr_trig = 1'b1; @(negedge clk); tmr_trig = 1'b0;
    idle(12);
    chk(conv_n == 0, "R6 timer disabled", conv_n, 0);
    wr(3'd2, 16'((1 << 2) | (1 << 10)));
    @(negedge clk); tmr_trig = 1'b1; @(negedge clk); tmr_trig = 1'b0;
    wait_idle();
    chk(conv_n == 2, "R6 timer enabled", conv_n, 2);

    // R6 external pin, edge triggered and gated
    wr(3'd2, 16'(1 << 11));
    conv_n = 0;
    @(negedge clk); ext_soc = 1'b1;
    idle(25);
    ext_soc = 1'b0;
    wait_idle();
    chk(conv_n == 1, "R6 pin edge once", conv_n, 1);
    wr(3'd2, 16'h0000);
    conv_n = 0;
    @(negedge clk); ext_soc = 1'b1; idle(6); ext_soc = 1'b0;
    idle(12);
    chk(conv_n == 0, "R6 pin disabled", conv_n, 0);

    // R7 pending start, extra start dropped
    wr(3'd2, 16'(1 << 2));
    conv_n = 0;
    wr(3'd3, 16'h0001);
    wr(3'd3, 16'h0001);
    wr(3'd3, 16'h0001);
    rdreg(3'd3, rd);
    chk(rd[2] == 1'b1, "R7 pending flag", rd[2], 1);
    wait_idle();
    chk(conv_n == 4, "R7 one pending run", conv_n, 4);

    // R5 continuous run then stop at end of sequence
    wr(3'd2, 16'(2 | (2 << 2)));
    conv_n = 0;
    wr(3'd3, 16'h0001);
    while (conv_n < 7) @(negedge clk);
    rdreg(3'd3, rd);
    chk(rd[0] == 1'b1, "R5 still busy", rd[0], 1);
    wr(3'd2, 16'(2 << 2));
    wait_idle();
    chk(conv_n % 3 == 0 && conv_n >= 9, "R5 stop at end", conv_n, 9);
    for (int i = 0; i < 9; i++)
      chk(ch_log[i] == nib(WA, i % 3), "R5 wrap order", ch_log[i], nib(WA, i % 3));

    // R10 reset mid-sequence
    wr(3'd2, 16'(3 << 2));
    conv_n = 0;
    wr(3'd3, 16'h0001);
    while (conv_n < 1) @(negedge clk);
    wr(3'd3, 16'h0008);
    idle(20);
    rdreg(3'd3, rd);
    chk(rd[0] == 1'b0 && rd[2] == 1'b0, "R10 busy cleared", rd, 0);
    chk(!adc_req, "R10 no request", adc_req, 0);
    rdreg(3'd2, rd);
    chk(rd == 16'(3 << 2), "R10 config kept", rd, 3 << 2);
    conv_n = 0;
    wr(3'd3, 16'h0001);
    wait_idle();
    chk(conv_n == 4 && ch_log[0] == nib(WA, 0), "R10 restart slot 0", ch_log[0], nib(WA, 0));

    // R9 write 0 keeps flag, write 1 clears
    wr(3'd2, 16'(1 << 6));
    wr(3'd3, 16'h0001);
    wait_idle();
    chk(irq_a == 1'b1, "R8 flag set", irq_a, 1);
    wr(3'd3, 16'h0000);
    rdreg(3'd3, rd);
    chk(irq_a == 1'b1 && rd[1], "R9 write 0 keeps", irq_a, 1);
    wr(3'd3, 16'h0002);
    chk(irq_a == 1'b0, "R9 write 1 clears", irq_a, 0);

    // R9 set and clear on the same edge: set wins
    clr_hit = 1'b1;
    wr(3'd3, 16'h0001);
    idle(30);
    chk(!clr_hit, "R9 collision reached", clr_hit, 0);
    chk(irq_a == 1'b1, "R9 set wins", irq_a, 1);
    wr(3'd3, 16'h0002);

    // R12 dual arbitration A before B, result register
    wr(3'd2, 16'((1 << 2) | (1 << 4) | (2 << 8)));
    conv_n = 0;
    wr(3'd3, 16'h0011);
    wait_idle();
    chk(conv_n == 4, "R12 count", conv_n, 4);
    chk(ch_log[0] == nib(WA, 0) && ch_log[1] == nib(WA, 1), "R12 A first",
        ch_log[1], nib(WA, 1));
    chk(ch_log[2] == nib(WB, 0) && ch_log[3] == nib(WB, 1), "R12 B after",
        ch_log[3], nib(WB, 1));
    chk(irq_b == 1'b1 && irq_a == 1'b0, "R8 B end irq", {irq_b, irq_a}, 2);
    rdreg(3'd4, rd);
    chk(rd == {4'h5, 8'd3, nib(WB, 1)}, "R12 result", rd, {4'h5, 8'd3, nib(WB, 1)});

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule